// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block derives a pixel-rate clock from the system clock and sequences a raster display's horizontal and vertical timing. It drives a pixel clock, a one-cycle pixel enable, horizontal sync, vertical sync and a data-enable strobe. A line has four phases in fixed order: sync, back porch, active pixels and front porch. The lines of a frame pass through the same four phases. Every phase length comes from a runtime configuration input, as do the clock divisor and the four output polarities.

The configuration is held in shadow registers. These registers follow the inputs while the block is disabled. While it runs they reload only at the instant a new frame begins, so a frame in progress keeps one consistent timing. Status outputs give the current line number within the frame and the current horizontal and vertical phase. Pixel data from elsewhere is launched on each pixel-enable cycle, which is the rising edge of the pixel clock, so that a receiver can sample it on the falling edge.

Top module: `raster_timing_gen`

## Requirements
- R1: With divisor field D, `pixTick` pulses once every 2*(D+1) system clocks. In its uninverted form `pixClkOut` rises in the cycle where `pixTick` is high and stays high for D+1 cycles.
- R2: Horizontal phases run sync, back porch, active, front porch, and then back to sync. `hPhase` reports them as 0, 1, 2, 3. The active phase lasts `cfgHActive`+1 pixels and each other phase lasts its field value in pixels.
- R3: Vertical phases run in the same order and use the same 0 to 3 code on `vPhase`, but they are counted in whole lines. The active phase lasts `cfgVActive`+1 lines.
- R4: A sync or porch field of 0 gives a phase of exactly one unit. No phase is ever skipped.
- R5: The data-enable is at its active level only when both phases are 2. It becomes active on the first `pixTick` of the active region.
- R6: Each output level is its active level XOR its invert bit. The inactive level equals the invert bit. With the pixel-clock invert bit set, `pixClkOut` is complemented.
- R7: While `cfgEnable` is 0, sync, data-enable and pixel clock sit at their inactive levels and `pixTick` is 0. Phases and `lineCount` read 0. After enable is set, the first pixel is the first sync pixel of the first sync line.
- R8: While the block is running, configuration changes take effect only at the next frame start. The frame in progress finishes with the old values.
- R9: `lineCount` is 0 on the first sync line of a frame, rises by one per line, and returns to 0 at the next frame start.
- R10: While enabled, sync, data-enable and `lineCount` change only in cycles where `pixTick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| cfgEnable | input | 1 | Global run enable |
| cfgClkDiv | input | DW | Pixel clock divisor field |
| cfgHSync | input | HW | Horizontal sync width, pixels |
| cfgHBack | input | HW | Horizontal back porch, pixels |
| cfgHActive | input | HW | Active pixels minus one |
| cfgHFront | input | HW | Horizontal front porch, pixels |
| cfgVSync | input | VW | Vertical sync width, lines |
| cfgVBack | input | VW | Vertical back porch, lines |
| cfgVActive | input | VW | Active lines minus one |
| cfgVFront | input | VW | Vertical front porch, lines |
| cfgInvHSync | input | 1 | Invert horizontal sync |
| cfgInvVSync | input | 1 | Invert vertical sync |
| cfgInvDe | input | 1 | Invert data-enable |
| cfgInvPixClk | input | 1 | Invert pixel clock |
| pixClkOut | output | 1 | Pixel clock |
| pixTick | output | 1 | One-cycle pulse at start of each pixel |
| hSyncOut | output | 1 | Horizontal sync |
| vSyncOut | output | 1 | Vertical sync |
| deOut | output | 1 | Data-enable strobe |
| hPhase | output | 2 | Horizontal phase status |
| vPhase | output | 2 | Vertical phase status |
| lineCount | output | VW+2 | Line number within frame |

## Verification
A scoreboard predicts the expected sync, data-enable, phase and line values for every pixel of whole frames. These predictions are tried against a small timing set with all polarities positive, against all four polarities inverted with zero-valued fields, and against a set whose widths and divisor are changed partway through a frame. The first set tells whether each phase has the right length and order. The second separates the polarity handling from the zero-clamping rule. The third shows whether new values leak into the frame in progress. Separate measurements of pixel period and pixel-clock duty cycle check the divisor, and a disable in the middle of a frame followed by a fresh frame checks the restart position.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  typedef enum logic [1:0] {
    PH_SYNC   = 2'd0,
    PH_BACK   = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_FRONT  = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;
    logic hStep;
    logic lineDone;
    logic vStep;
    logic frameWrap;
  } strobe_t;

  // end-of-phase flags from datapath to control
  typedef struct packed {
    logic hLast;
    logic vLast;
  } flags_t;
endpackage

// File: rtl/rtg_ctrl.sv
module rtg_ctrl
  import rtg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic [DW-1:0] divisor,
  input  flags_t        flags,
  output strobe_t       strobe,
  output phase_e        hPhase,
  output phase_e        vPhase,
  output logic          pclk,
  output logic          running,
  output logic          tickQ
);
  logic [DW-1:0] divCnt;
  logic          divEnd;
  logic          tick;

  assign divEnd = (divCnt >= divisor);
  // pixel clock rises at the edge that ends this cycle
  assign tick   = enable && divEnd && !pclk;

  always_comb begin
    strobe.advance   = tick && running;
    strobe.hStep     = strobe.advance && flags.hLast;
    strobe.lineDone  = strobe.hStep && (hPhase == PH_FRONT);
    strobe.vStep     = strobe.lineDone && flags.vLast;
    strobe.frameWrap = strobe.vStep && (vPhase == PH_FRONT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      pclk    <= 1'b0;
      running <= 1'b0;
      tickQ   <= 1'b0;
      hPhase  <= PH_SYNC;
      vPhase  <= PH_SYNC;
    end else if (!enable) begin
      divCnt  <= '0;
      pclk    <= 1'b0;
      running <= 1'b0;
      tickQ   <= 1'b0;
      hPhase  <= PH_SYNC;
      vPhase  <= PH_SYNC;
    end else begin
      divCnt <= divEnd ? '0 : divCnt + 1'b1;
      if (divEnd) pclk <= ~pclk;
      tickQ <= tick;
      if (tick && !running) running <= 1'b1;
      if (strobe.hStep) hPhase <= phase_e'(hPhase + 2'd1);
      if (strobe.vStep) vPhase <= phase_e'(vPhase + 2'd1);
    end
  end
endmodule

// File: rtl/rtg_datapath.sv
module rtg_datapath
  import rtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int DW = 8,
  parameter int LW = VW + 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic [DW-1:0] cfgClkDiv,
  input  logic [HW-1:0] cfgHSync,
  input  logic [HW-1:0] cfgHBack,
  input  logic [HW-1:0] cfgHActive,
  input  logic [HW-1:0] cfgHFront,
  input  logic [VW-1:0] cfgVSync,
  input  logic [VW-1:0] cfgVBack,
  input  logic [VW-1:0] cfgVActive,
  input  logic [VW-1:0] cfgVFront,
  input  logic          cfgInvHSync,
  input  logic          cfgInvVSync,
  input  logic          cfgInvDe,
  input  logic          cfgInvPixClk,
  input  strobe_t       strobe,
  input  phase_e        hPhase,
  input  phase_e        vPhase,
  output flags_t        flags,
  output logic [LW-1:0] lineCount,
  output logic [DW-1:0] shDiv,
  output logic          shInvH,
  output logic          shInvV,
  output logic          shInvDe,
  output logic          shInvPclk
);
  logic [HW-1:0] shHSync, shHBack, shHActive, shHFront;
  logic [VW-1:0] shVSync, shVBack, shVActive, shVFront;
  logic [HW-1:0] hCnt, hLastVal;
  logic [VW-1:0] vCnt, vLastVal;
  logic          loadShadow;

  function automatic logic [HW-1:0] hMinusOne(input logic [HW-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  function automatic logic [VW-1:0] vMinusOne(input logic [VW-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  assign loadShadow = !enable || strobe.frameWrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shDiv <= '0;
      {shHSync, shHBack, shHActive, shHFront} <= '0;
      {shVSync, shVBack, shVActive, shVFront} <= '0;
      {shInvH, shInvV, shInvDe, shInvPclk} <= '0;
    end else if (loadShadow) begin
      shDiv     <= cfgClkDiv;
      shHSync   <= cfgHSync;
      shHBack   <= cfgHBack;
      shHActive <= cfgHActive;
      shHFront  <= cfgHFront;
      shVSync   <= cfgVSync;
      shVBack   <= cfgVBack;
      shVActive <= cfgVActive;
      shVFront  <= cfgVFront;
      shInvH    <= cfgInvHSync;
      shInvV    <= cfgInvVSync;
      shInvDe   <= cfgInvDe;
      shInvPclk <= cfgInvPixClk;
    end
  end

  always_comb begin
    unique case (hPhase)
      PH_SYNC:   hLastVal = hMinusOne(shHSync);
      PH_BACK:   hLastVal = hMinusOne(shHBack);
      PH_ACTIVE: hLastVal = shHActive;
      default:   hLastVal = hMinusOne(shHFront);
    endcase
    unique case (vPhase)
      PH_SYNC:   vLastVal = vMinusOne(shVSync);
      PH_BACK:   vLastVal = vMinusOne(shVBack);
      PH_ACTIVE: vLastVal = shVActive;
      default:   vLastVal = vMinusOne(shVFront);
    endcase
  end

  assign flags.hLast = (hCnt >= hLastVal);
  assign flags.vLast = (vCnt >= vLastVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt      <= '0;
      vCnt      <= '0;
      lineCount <= '0;
    end else if (!enable) begin
      hCnt      <= '0;
      vCnt      <= '0;
      lineCount <= '0;
    end else begin
      if (strobe.advance)
        hCnt <= flags.hLast ? '0 : hCnt + 1'b1;
      if (strobe.lineDone) begin
        vCnt      <= flags.vLast ? '0 : vCnt + 1'b1;
        lineCount <= strobe.frameWrap ? '0 : lineCount + 1'b1;
      end
    end
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int DW = 8,
  localparam int LW = VW + 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgEnable,
  input  logic [DW-1:0] cfgClkDiv,
  input  logic [HW-1:0] cfgHSync,
  input  logic [HW-1:0] cfgHBack,
  input  logic [HW-1:0] cfgHActive,
  input  logic [HW-1:0] cfgHFront,
  input  logic [VW-1:0] cfgVSync,
  input  logic [VW-1:0] cfgVBack,
  input  logic [VW-1:0] cfgVActive,
  input  logic [VW-1:0] cfgVFront,
  input  logic          cfgInvHSync,
  input  logic          cfgInvVSync,
  input  logic          cfgInvDe,
  input  logic          cfgInvPixClk,
  output logic          pixClkOut,
  output logic          pixTick,
  output logic          hSyncOut,
  output logic          vSyncOut,
  output logic          deOut,
  output logic [1:0]    hPhase,
  output logic [1:0]    vPhase,
  output logic [LW-1:0] lineCount
);
  strobe_t       strobe;
  flags_t        flags;
  phase_e        hPh, vPh;
  logic          pclk, running, tickQ, live;
  logic [DW-1:0] shDiv;
  logic          shInvH, shInvV, shInvDe, shInvPclk;

  rtg_ctrl #(.DW(DW)) i_ctrl (
    .clk(clk), .rstN(rstN), .enable(cfgEnable), .divisor(shDiv),
    .flags(flags), .strobe(strobe), .hPhase(hPh), .vPhase(vPh),
    .pclk(pclk), .running(running), .tickQ(tickQ)
  );

  rtg_datapath #(.HW(HW), .VW(VW), .DW(DW), .LW(LW)) i_dp (
    .clk(clk), .rstN(rstN), .enable(cfgEnable), .cfgClkDiv(cfgClkDiv),
    .cfgHSync(cfgHSync), .cfgHBack(cfgHBack), .cfgHActive(cfgHActive),
    .cfgHFront(cfgHFront), .cfgVSync(cfgVSync), .cfgVBack(cfgVBack),
    .cfgVActive(cfgVActive), .cfgVFront(cfgVFront),
    .cfgInvHSync(cfgInvHSync), .cfgInvVSync(cfgInvVSync),
    .cfgInvDe(cfgInvDe), .cfgInvPixClk(cfgInvPixClk),
    .strobe(strobe), .hPhase(hPh), .vPhase(vPh), .flags(flags),
    .lineCount(lineCount), .shDiv(shDiv), .shInvH(shInvH),
    .shInvV(shInvV), .shInvDe(shInvDe), .shInvPclk(shInvPclk)
  );

  assign live      = cfgEnable && running;
  assign hSyncOut  = (live && hPh == PH_SYNC) ^ shInvH;
  assign vSyncOut  = (live && vPh == PH_SYNC) ^ shInvV;
  assign deOut     = (live && hPh == PH_ACTIVE && vPh == PH_ACTIVE) ^ shInvDe;
  assign pixClkOut = (cfgEnable && pclk) ^ shInvPclk;
  assign pixTick   = cfgEnable && tickQ;
  assign hPhase    = hPh;
  assign vPhase    = vPh;
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
  parameter int LW = 13
) (
  input logic          clk,
  input logic          rstN,
  input logic          enable,
  input logic          pixTick,
  input logic          pixClkOut,
  input logic          hSyncOut,
  input logic          vSyncOut,
  input logic          deOut,
  input logic [1:0]    hPhase,
  input logic [1:0]    vPhase,
  input logic [LW-1:0] lineCount,
  input logic          invDe
);
  // R1
  tick_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable && $past(enable) && pixTick |-> pixClkOut != $past(pixClkOut));

  // R2
  h_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable && $past(enable) && hPhase != $past(hPhase)
      |-> hPhase == 2'($past(hPhase) + 2'd1));

  // R3
  v_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable && $past(enable) && vPhase != $past(vPhase)
      |-> vPhase == 2'($past(vPhase) + 2'd1));

  // R5
  de_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    deOut != invDe |-> hPhase == 2'd2 && vPhase == 2'd2);

  // R7
  idle_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable && !$past(enable)
      |-> !pixTick && hPhase == 2'd0 && vPhase == 2'd0 && lineCount == '0);

  // R9
  line_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable && $past(enable) && lineCount != $past(lineCount)
      |-> lineCount == '0 || lineCount == $past(lineCount) + 1'b1);

  // R10
  sync_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable && $past(enable) &&
    (!$stable(hSyncOut) || !$stable(vSyncOut) || !$stable(deOut) || !$stable(lineCount))
      |-> pixTick);
endmodule

bind raster_timing_gen rtg_checker i_rtg_checker (
  .clk(clk), .rstN(rstN), .enable(cfgEnable), .pixTick(pixTick),
  .pixClkOut(pixClkOut), .hSyncOut(hSyncOut), .vSyncOut(vSyncOut),
  .deOut(deOut), .hPhase(hPhase), .vPhase(vPhase), .lineCount(lineCount),
  .invDe(shInvDe)
);

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;
  localparam int HW = 12, VW = 11, DW = 8, LW = VW + 2;

  typedef struct {
    int d, hs, hb, ha, hf, vs, vb, va, vf;
    bit iH, iV, iD, iP;
  } cfg_s;

  typedef struct {
    logic hs, vs, de;
    logic [1:0] hp, vp;
    int line;
  } item_s;

  logic clk = 1'b0, rstN = 1'b0, cfgEnable = 1'b0;
  logic [DW-1:0] cfgClkDiv = '0;
  logic [HW-1:0] cfgHSync = '0, cfgHBack = '0, cfgHActive = '0, cfgHFront = '0;
  logic [VW-1:0] cfgVSync = '0, cfgVBack = '0, cfgVActive = '0, cfgVFront = '0;
  logic cfgInvHSync = 1'b0, cfgInvVSync = 1'b0, cfgInvDe = 1'b0, cfgInvPixClk = 1'b0;
  logic pixClkOut, pixTick, hSyncOut, vSyncOut, deOut;
  logic [1:0] hPhase, vPhase;
  logic [LW-1:0] lineCount;

  int tests = 0, fails = 0, popped = 0;
  bit finished = 0;
  string curTag = "R2";
  item_s q[$];

  always #2 clk = ~clk;  // 250 MHz

  raster_timing_gen #(.HW(HW), .VW(VW), .DW(DW)) i_raster_timing_gen (.*);

  task automatic check(string tag, int act, int exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic applyCfg(cfg_s c);
    cfgClkDiv = DW'(c.d);
    cfgHSync = HW'(c.hs); cfgHBack = HW'(c.hb); cfgHActive = HW'(c.ha); cfgHFront = HW'(c.hf);
    cfgVSync = VW'(c.vs); cfgVBack = VW'(c.vb); cfgVActive = VW'(c.va); cfgVFront = VW'(c.vf);
    cfgInvHSync = c.iH; cfgInvVSync = c.iV; cfgInvDe = c.iD; cfgInvPixClk = c.iP;
  endtask

  function automatic int unitLen(int f);
    return (f == 0) ? 1 : f;  // R4: zero counts as one
  endfunction

  // Driver: expected per-pixel items for one frame (R2, R3, R5, R6, R9)
  task automatic pushFrame(cfg_s c);
    int line = 0;
    int vLen[4], hLen[4];
    item_s it;
    vLen[0] = unitLen(c.vs); vLen[1] = unitLen(c.vb); vLen[2] = c.va + 1; vLen[3] = unitLen(c.vf);
    hLen[0] = unitLen(c.hs); hLen[1] = unitLen(c.hb); hLen[2] = c.ha + 1; hLen[3] = unitLen(c.hf);
    for (int vp = 0; vp < 4; vp++)
      for (int vl = 0; vl < vLen[vp]; vl++) begin
        for (int hp = 0; hp < 4; hp++)
          for (int px = 0; px < hLen[hp]; px++) begin
            it.hs = (hp == 0) ^ c.iH;
            it.vs = (vp == 0) ^ c.iV;
            it.de = (hp == 2 && vp == 2) ^ c.iD;
            it.hp = 2'(hp); it.vp = 2'(vp);
            it.line = line;
            q.push_back(it);
          end
        line++;
      end
  endtask

  // Monitor: compares each pixel as pixTick marks it
  always @(negedge clk) begin
    if (rstN && pixTick && q.size() > 0) begin
      item_s e;
      e = q.pop_front();
      popped++;
      tests++;
      if (hSyncOut !== e.hs || vSyncOut !== e.vs || deOut !== e.de ||
          hPhase !== e.hp || vPhase !== e.vp || int'(lineCount) != e.line) begin
        fails++;
        $display("FAIL %s pixel %0d: actual hs%0b vs%0b de%0b hp%0d vp%0d ln%0d expected hs%0b vs%0b de%0b hp%0d vp%0d ln%0d",
                 curTag, popped, hSyncOut, vSyncOut, deOut, hPhase, vPhase, lineCount,
                 e.hs, e.vs, e.de, e.hp, e.vp, e.line);
      end
    end
  end

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    cfgEnable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic checkIdle(string tag, bit iH, bit iV, bit iD, bit iP);
    check(tag, hSyncOut, iH, "idle hsync");
    check(tag, vSyncOut, iV, "idle vsync");
    check(tag, deOut, iD, "idle de");
    check(tag, pixClkOut, iP, "idle pixclk");
    check(tag, pixTick, 0, "idle pixTick");
    check(tag, hPhase, 0, "idle hPhase");
    check(tag, vPhase, 0, "idle vPhase");
    check(tag, int'(lineCount), 0, "idle lineCount");
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    cfg_s a, b, p;
    a = '{d:0, hs:2, hb:1, ha:3, hf:1, vs:1, vb:2, va:1, vf:2, iH:0, iV:0, iD:0, iP:0};
    applyCfg(a);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R7: reset and idle levels
    checkIdle("R7", 0, 0, 0, 0);

    // R2 R3 R5 R9: two frames, all polarities positive
    curTag = "R2/R3/R5/R9";
    pushFrame(a); pushFrame(a);
    cfgEnable = 1'b1;
    drain();

    // R1: divisor 2 gives 6-cycle pixel period, 3 cycles high
    b = a; b.d = 2;
    applyCfg(b);
    repeat (2) @(negedge clk);
    cfgEnable = 1'b1;
    for (int k = 0; k < 3; k++) begin
      int n, hi;
      while (!pixTick) @(negedge clk);
      n = 1; hi = pixClkOut ? 1 : 0;
      @(negedge clk);
      while (!pixTick) begin
        n++; if (pixClkOut) hi++;
        @(negedge clk);
      end
      check("R1", n, 6, "pixel period");
      check("R1", hi, 3, "pixel clock high time");
    end
    cfgEnable = 1'b0;
    repeat (3) @(negedge clk);

    // R4 R6: all inverted, zero fields clamp to one
    p = '{d:1, hs:3, hb:0, ha:2, hf:0, vs:0, vb:1, va:2, vf:0, iH:1, iV:1, iD:1, iP:1};
    applyCfg(p);
    repeat (3) @(negedge clk);
    checkIdle("R6", 1, 1, 1, 1);
    curTag = "R4/R6";
    pushFrame(p); pushFrame(p);
    cfgEnable = 1'b1;
    drain();
    checkIdle("R7", 1, 1, 1, 1);

    // R8: change mid-frame; old frame completes, new one follows
    applyCfg(a);
    repeat (3) @(negedge clk);
    b = a; b.d = 1; b.ha = 5; b.vf = 1; b.hs = 1; b.iH = 1;
    curTag = "R8";
    pushFrame(a); pushFrame(b); pushFrame(b);
    popped = 0;
    cfgEnable = 1'b1;
    while (popped < 10) @(negedge clk);
    applyCfg(b);
    drain();

    // R7: disable mid-frame, then restart from top of frame
    applyCfg(a);
    repeat (3) @(negedge clk);
    cfgEnable = 1'b1;
    repeat (60) @(negedge clk);
    cfgEnable = 1'b0;
    @(negedge clk);
    check("R7", pixTick, 0, "pixTick after disable");
    check("R7", hSyncOut, 0, "hsync after disable");
    @(negedge clk);
    check("R7", int'(lineCount), 0, "lineCount after disable");
    curTag = "R7";
    pushFrame(a);
    cfgEnable = 1'b1;
    drain();

    report();
  end
endmodule